// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the device side of a byte-wide parallel programming port for an on-chip code store. The code store is a register array of `2**ADDR_W` bytes, 4 KB by default. An external programmer drives an entry strap, a program-store strobe, four mode-select pins, a "high voltage present" flag, an address and a data byte. It then pulses an active-low program strobe. The block decodes the pin combination into one of seven operations: byte write, byte read, chip erase, signature read, or setting one of three lock bits.

Byte writes and lock-bit writes run a self-timed busy cycle whose length comes from the clock frequency and a write-time parameter. A ready output reports this cycle. During the cycle, a read of the address being written returns polling data with bit 7 inverted. A byte may only be written when it is blank (FFh), so rewriting a byte needs a chip erase first. Chip erase needs the strobe held low for a programmable time. Three lock bits give cumulative protection levels that block further writes, then block verify reads, then block external execution. Three fixed signature bytes can be read at any lock level.

Top module: `flash_prog_ctrl`

## Requirements
- R1: An operation is decoded only while `prog_entry`=1 and `pstore_n`=0. `mode_pins` is {pinA,pinB,pinC,pinD} as bits 3..0, and the codes are: write 0111, read 0011, erase 1000, signature 0000, lock1 1111, lock2 1100, lock3 1010. Any other combination, or either strap inactive, selects no operation and holds `dout_en` low.
- R2: A byte write starts on the rising edge of `prog_n` when the write code is selected and `hv_ok`=1. `ready` is low from the next clock for exactly WRITE_TICKS (CLK_MHZ*WRITE_US) cycles. After that, the new byte is readable.
- R3: While a byte write is busy, a read of that address returns the written byte with bit 7 inverted. Reads of other addresses return stored data. Once `ready` is back, true data is returned.
- R4: A byte write to a location that is not FFh is ignored: `ready` stays high and the stored byte is unchanged.
- R5: In erase mode with `hv_ok`=1, holding `prog_n` low for ERASE_TICKS (CLK_MHZ*ERASE_US) cycles sets every byte to FFh and clears all lock bits. A shorter low pulse changes nothing. After an erase, a blank byte can be written again.
- R6: Signature mode returns 1Eh at address 030h, 61h at 031h and FFh at 032h, and 00h at every other address.
- R7: The three lock codes each set their own lock bit with a self-timed busy cycle. When lock bit 1 is set (level 2), byte writes are ignored and no busy cycle starts.
- R8: When lock bits 1 and 2 are both set (level 3), code reads return 00h.
- R9: `ext_exec_ok` is low only when all three lock bits are set (level 4).
- R10: `dout` is registered and reflects the mode and address one clock after they are applied. `dout_en` is high in read and signature modes.
- R11: With `hv_ok`=0, byte write, lock write and erase requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; code store resets to blank |
| prog_entry | input | 1 | Programming entry strap, active high |
| pstore_n | input | 1 | Program-store strobe, must be low for any operation |
| hv_ok | input | 1 | Programming voltage present |
| mode_pins | input | 4 | Mode-select pins A..D (bit 3 = A) |
| prog_n | input | 1 | Active-low program strobe |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| dout_en | output | 1 | Read data driven |
| ready | output | 1 | High when no self-timed cycle is running |
| ext_exec_ok | output | 1 | External execution permitted |

## Verification
A fault in the busy counter or the latched write address shows up on `ready` within one write period: the bench counts the exact cycles `ready` is low. It also shows up in polling data, which is checked one cycle into the busy window. A wrong blank or lock decision shows up as a `ready` pulse that should not appear, or one that is missing, on the cycle after the strobe's rising edge. It also shows up later as a wrong byte on a verify read. Lock-bit state is visible through `ext_exec_ok` and through code reads returning 00h, so a lost or spurious erase shows at the next read.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_WRITE,
      OP_READ,
      OP_ERASE,
      OP_SIG,
      OP_LOCK1,
      OP_LOCK2,
      OP_LOCK3
   } prog_op_e;

   localparam logic [3:0] PINS_WRITE = 4'b0111;
   localparam logic [3:0] PINS_READ  = 4'b0011;
   localparam logic [3:0] PINS_ERASE = 4'b1000;
   localparam logic [3:0] PINS_SIG   = 4'b0000;
   localparam logic [3:0] PINS_LOCK1 = 4'b1111;
   localparam logic [3:0] PINS_LOCK2 = 4'b1100;
   localparam logic [3:0] PINS_LOCK3 = 4'b1010;

   localparam int          SIG_BASE  = 'h30;
   localparam logic [7:0]  SIG_BYTE0 = 8'h1E;
   localparam logic [7:0]  SIG_BYTE1 = 8'h61;
   localparam logic [7:0]  SIG_BYTE2 = 8'hFF;

   localparam int LOCK_BITS = 3;

endpackage

// File: rtl/flash_mode_dec.sv
module flash_mode_dec
   import flash_prog_pkg::*;
(
   input  logic       prog_entry,
   input  logic       pstore_n,
   input  logic [3:0] mode_pins,
   output prog_op_e   op
);

   always_comb begin
      op = OP_NONE;
      if (prog_entry && !pstore_n) begin
         unique case (mode_pins)
            PINS_WRITE: op = OP_WRITE;
            PINS_READ:  op = OP_READ;
            PINS_ERASE: op = OP_ERASE;
            PINS_SIG:   op = OP_SIG;
            PINS_LOCK1: op = OP_LOCK1;
            PINS_LOCK2: op = OP_LOCK2;
            PINS_LOCK3: op = OP_LOCK3;
            default:    op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/flash_code_array.sv
module flash_code_array
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 erase,
   input  logic [LOCK_BITS-1:0] lock_set,
   output logic [LOCK_BITS-1:0] lock_bits
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
         lock_bits <= '0;
      end else if (erase) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
         lock_bits <= '0;
      end else begin
         if (wr_en) mem[wr_addr] <= wr_data;
         lock_bits <= lock_bits | lock_set;
      end
   end

   assign rd_data = mem[rd_addr];

   // R4: a byte is only ever written onto an erased location
   p_blank_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (mem[wr_addr] == {DATA_W{1'b1}}));

   // R5: erase leaves all lock bits clear and the read location blank
   p_erase_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (lock_bits == '0) && (mem[$past(rd_addr)] == {DATA_W{1'b1}}));

   // R7: lock bits only ever accumulate until an erase
   p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !erase |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 8,
   parameter int WRITE_TICKS = 18000,
   parameter int ERASE_TICKS = 120000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  prog_op_e             op,
   input  logic                 prog_n,
   input  logic                 hv_ok,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    din,
   input  logic                 blank,
   input  logic                 prog_locked,
   output logic                 busy,
   output logic                 wr_en,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]    wr_data,
   output logic [LOCK_BITS-1:0] lock_set,
   output logic                 erase,
   output logic                 poll_valid
);

   localparam int WCW = $clog2(WRITE_TICKS + 1);
   localparam int ECW = $clog2(ERASE_TICKS + 1);
   localparam logic [WCW-1:0] W_LAST = WCW'(WRITE_TICKS - 1);
   localparam logic [ECW-1:0] E_LAST = ECW'(ERASE_TICKS - 1);

   generate
      if (WRITE_TICKS < 1) begin : g_bad_write
         $error("WRITE_TICKS must be at least 1");
      end
      if (ERASE_TICKS < 1) begin : g_bad_erase
         $error("ERASE_TICKS must be at least 1");
      end
   endgenerate

   logic                 prog_q;
   logic                 rise;
   logic                 is_lock;
   logic [LOCK_BITS-1:0] lock_pick;
   logic                 accept_byte, accept_lock;
   logic [WCW-1:0]       wcnt;
   logic [ECW-1:0]       ecnt;
   logic                 erase_fired;
   logic                 erase_hold;
   logic [LOCK_BITS-1:0] lat_lock;
   logic                 done;

   always_comb begin
      lock_pick = '0;
      case (op)
         OP_LOCK1: lock_pick = 3'b001;
         OP_LOCK2: lock_pick = 3'b010;
         OP_LOCK3: lock_pick = 3'b100;
         default:  lock_pick = '0;
      endcase
   end

   assign is_lock     = |lock_pick;
   assign rise        = prog_n && !prog_q;
   assign accept_byte = rise && !busy && hv_ok && (op == OP_WRITE) && blank && !prog_locked;
   assign accept_lock = rise && !busy && hv_ok && is_lock;
   assign done        = busy && (wcnt == W_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q   <= 1'b1;
         busy     <= 1'b0;
         wcnt     <= '0;
         wr_addr  <= '0;
         wr_data  <= '0;
         lat_lock <= '0;
      end else begin
         prog_q <= prog_n;
         if (accept_byte || accept_lock) begin
            busy     <= 1'b1;
            wcnt     <= '0;
            wr_addr  <= addr;
            wr_data  <= din;
            lat_lock <= accept_lock ? lock_pick : '0;
         end else if (busy) begin
            if (done) busy <= 1'b0;
            else      wcnt <= wcnt + 1'b1;
         end
      end
   end

   assign wr_en      = done && (lat_lock == '0);
   assign lock_set   = done ? lat_lock : '0;
   assign poll_valid = busy && (lat_lock == '0);

   assign erase_hold = !prog_n && !busy && hv_ok && (op == OP_ERASE) && !erase_fired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt        <= '0;
         erase       <= 1'b0;
         erase_fired <= 1'b0;
      end else begin
         erase <= 1'b0;
         if (prog_n) erase_fired <= 1'b0;
         if (erase_hold) begin
            if (ecnt == E_LAST) begin
               erase       <= 1'b1;
               erase_fired <= 1'b1;
               ecnt        <= '0;
            end else begin
               ecnt <= ecnt + 1'b1;
            end
         end else begin
            ecnt <= '0;
         end
      end
   end

   // R2: an accepted request makes the block busy on the next cycle
   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_byte || accept_lock) |=> busy);

   // R2: the busy window never exceeds the programmed write time
   p_busy_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (wcnt <= W_LAST));

   // R2: a completed write releases busy on the next cycle
   p_done_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R7: a byte write never starts on a locked device
   p_locked_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && (lat_lock == '0)) |-> !$past(prog_locked));

   // R11: nothing starts without programming voltage
   p_needs_hv_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) || erase) |-> $past(hv_ok));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int CLK_MHZ  = 12,
   parameter int WRITE_US = 1500,
   parameter int ERASE_US = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_entry,
   input  logic              pstore_n,
   input  logic              hv_ok,
   input  logic [3:0]        mode_pins,
   input  logic              prog_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_en,
   output logic              ready,
   output logic              ext_exec_ok
);

   localparam int DATA_W      = 8;
   localparam int WRITE_TICKS = CLK_MHZ * WRITE_US;
   localparam int ERASE_TICKS = CLK_MHZ * ERASE_US;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must reach the signature addresses");
      end
   endgenerate

   prog_op_e             op;
   logic [DATA_W-1:0]    rd_data;
   logic                 busy, wr_en, erase, poll_valid;
   logic [ADDR_W-1:0]    wr_addr;
   logic [DATA_W-1:0]    wr_data;
   logic [LOCK_BITS-1:0] lock_set, lock_bits;
   logic [LOCK_BITS-1:0] level_on;
   logic [DATA_W-1:0]    sig_val;
   logic [DATA_W-1:0]    code_val;

   flash_mode_dec u_dec (
      .prog_entry (prog_entry),
      .pstore_n   (pstore_n),
      .mode_pins  (mode_pins),
      .op         (op)
   );

   flash_code_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (addr),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .erase     (erase),
      .lock_set  (lock_set),
      .lock_bits (lock_bits)
   );

   flash_prog_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .WRITE_TICKS (WRITE_TICKS),
      .ERASE_TICKS (ERASE_TICKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .prog_n      (prog_n),
      .hv_ok       (hv_ok),
      .addr        (addr),
      .din         (din),
      .blank       (rd_data == {DATA_W{1'b1}}),
      .prog_locked (level_on[0]),
      .busy        (busy),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .lock_set    (lock_set),
      .erase       (erase),
      .poll_valid  (poll_valid)
   );

   // cumulative protection: level_on[i] means lock bits 0..i are all set
   genvar gi;
   generate
      for (gi = 0; gi < LOCK_BITS; gi++) begin : g_level
         assign level_on[gi] = &lock_bits[gi:0];
      end
   endgenerate

   always_comb begin
      if (addr == ADDR_W'(SIG_BASE))          sig_val = SIG_BYTE0;
      else if (addr == ADDR_W'(SIG_BASE + 1)) sig_val = SIG_BYTE1;
      else if (addr == ADDR_W'(SIG_BASE + 2)) sig_val = SIG_BYTE2;
      else                                    sig_val = '0;
   end

   always_comb begin
      if (level_on[1])
         code_val = '0;
      else if (poll_valid && (addr == wr_addr))
         code_val = {~wr_data[DATA_W-1], wr_data[DATA_W-2:0]};
      else
         code_val = rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else begin
         case (op)
            OP_READ: dout <= code_val;
            OP_SIG:  dout <= sig_val;
            default: dout <= '0;
         endcase
      end
   end

   assign dout_en     = (op == OP_READ) || (op == OP_SIG);
   assign ready       = !busy;
   assign ext_exec_ok = !level_on[2];

   // R1: no read data is driven outside programming entry
   p_entry_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_entry || pstore_n) |-> !dout_en);

   // R8: verify-locked reads return zero
   p_verify_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_READ) && level_on[1]) |=> (dout == '0));

   // R9: external execution is refused only when every lock bit is set
   p_ext_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_exec_ok == !(&lock_bits) || $past(erase));

endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;

   localparam int ADDR_W   = 8;
   localparam int CLK_MHZ  = 1;
   localparam int WRITE_US = 20;
   localparam int ERASE_US = 40;
   localparam int WT       = CLK_MHZ * WRITE_US;
   localparam int ET       = CLK_MHZ * ERASE_US;

   localparam logic [3:0] P_WR = 4'b0111;
   localparam logic [3:0] P_RD = 4'b0011;
   localparam logic [3:0] P_ER = 4'b1000;
   localparam logic [3:0] P_SG = 4'b0000;
   localparam logic [3:0] P_L1 = 4'b1111;
   localparam logic [3:0] P_L2 = 4'b1100;
   localparam logic [3:0] P_L3 = 4'b1010;

   localparam int K_DOUT = 0;
   localparam int K_RDY  = 1;
   localparam int K_EXT  = 2;
   localparam int K_DEN  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prog_entry = 1'b1;
   logic              pstore_n = 1'b0;
   logic              hv_ok = 1'b1;
   logic [3:0]        mode_pins = 4'b0101;
   logic              prog_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        din = '0;
   logic [7:0]        dout;
   logic              dout_en, ready, ext_exec_ok;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   typedef struct {
      int         due;
      int         kind;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sb[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   flash_prog_ctrl #(
      .ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .WRITE_US(WRITE_US), .ERASE_US(ERASE_US)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .prog_entry(prog_entry), .pstore_n(pstore_n),
      .hv_ok(hv_ok), .mode_pins(mode_pins), .prog_n(prog_n), .addr(addr),
      .din(din), .dout(dout), .dout_en(dout_en), .ready(ready),
      .ext_exec_ok(ext_exec_ok)
   );

   task automatic expect_at(input int due, input int kind, input logic [7:0] exp, input string tag);
      item_t it;
      it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: pops due items and compares against the ports
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            logic [7:0] act;
            case (sb[i].kind)
               K_DOUT:  act = dout;
               K_RDY:   act = {7'd0, ready};
               K_EXT:   act = {7'd0, ext_exec_ok};
               default: act = {7'd0, dout_en};
            endcase
            checks++;
            if (act !== sb[i].exp) begin
               failures++;
               $display("FAIL %s kind=%0d cyc=%0d actual=%02h expected=%02h",
                        sb[i].tag, sb[i].kind, cyc, act, sb[i].exp);
            end
            sb.delete(i);
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic rd(input logic [3:0] pins, input logic [ADDR_W-1:0] a,
                     input logic [7:0] exp, input string tag);
      step();
      mode_pins = pins; addr = a;
      expect_at(cyc + 1, K_DOUT, exp, tag);
      step();
   endtask

   // strobe a write-type request; optionally probe polling data while busy
   task automatic strobe(input logic [3:0] pins, input logic [ADDR_W-1:0] a,
                         input logic [7:0] d, input bit hv, input bit exp_busy,
                         input bit poll, input string tag);
      int c;
      step();
      mode_pins = pins; addr = a; din = d; hv_ok = hv; prog_n = 1'b0;
      step();
      step();
      prog_n = 1'b1;
      c = cyc;
      if (exp_busy) begin
         expect_at(c + 1, K_RDY, 8'd0, tag);
         expect_at(c + WT, K_RDY, 8'd0, tag);
         expect_at(c + WT + 1, K_RDY, 8'd1, tag);
      end else begin
         expect_at(c + 1, K_RDY, 8'd1, tag);
         expect_at(c + 2, K_RDY, 8'd1, tag);
      end
      if (poll) begin
         step();
         mode_pins = P_RD; addr = a;
         expect_at(cyc + 1, K_DOUT, {~d[7], d[6:0]}, "R3 poll");
         step();
         addr = a + 1'b1;
         expect_at(cyc + 1, K_DOUT, 8'hFF, "R3 other addr");
      end
      repeat (WT + 3) step();
      hv_ok = 1'b1;
   endtask

   task automatic erase_pulse(input int hold);
      step();
      mode_pins = P_ER; hv_ok = 1'b1; prog_n = 1'b0;
      repeat (hold) step();
      prog_n = 1'b1;
      repeat (3) step();
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state (R1, R9)
      expect_at(cyc, K_RDY, 8'd1, "R2 reset ready");
      expect_at(cyc, K_EXT, 8'd1, "R9 reset ext");
      expect_at(cyc, K_DEN, 8'd0, "R1 undefined code");
      expect_at(cyc, K_DOUT, 8'd0, "R10 reset dout");
      step();

      // R10 blank read, R6 signatures
      rd(P_RD, 8'h05, 8'hFF, "R10 blank read");
      expect_at(cyc, K_DEN, 8'd1, "R10 dout_en");
      rd(P_SG, 8'h30, 8'h1E, "R6 sig0");
      rd(P_SG, 8'h31, 8'h61, "R6 sig1");
      rd(P_SG, 8'h32, 8'hFF, "R6 sig2");
      rd(P_SG, 8'h33, 8'h00, "R6 other");

      // R1: strap gating
      step(); prog_entry = 1'b0; mode_pins = P_RD;
      expect_at(cyc, K_DEN, 8'd0, "R1 entry low");
      step(); prog_entry = 1'b1; pstore_n = 1'b1;
      expect_at(cyc, K_DEN, 8'd0, "R1 pstore high");
      step(); pstore_n = 1'b0;

      // R2, R3 write with polling
      strobe(P_WR, 8'h05, 8'h5A, 1'b1, 1'b1, 1'b1, "R2 write busy");
      rd(P_RD, 8'h05, 8'h5A, "R3 true data");
      strobe(P_WR, 8'h09, 8'hC3, 1'b1, 1'b1, 1'b1, "R2 write busy b7");
      rd(P_RD, 8'h09, 8'hC3, "R2 written");

      // R4 non-blank rewrite ignored
      strobe(P_WR, 8'h05, 8'h11, 1'b1, 1'b0, 1'b0, "R4 no busy");
      rd(P_RD, 8'h05, 8'h5A, "R4 unchanged");

      // R11 no voltage
      strobe(P_WR, 8'h07, 8'h22, 1'b0, 1'b0, 1'b0, "R11 no busy");
      rd(P_RD, 8'h07, 8'hFF, "R11 unchanged");
      strobe(P_L1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R11 lock no busy");

      // R7 lock level 2
      strobe(P_L1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, "R7 lock1 busy");
      strobe(P_WR, 8'h08, 8'h33, 1'b1, 1'b0, 1'b0, "R7 locked no busy");
      rd(P_RD, 8'h08, 8'hFF, "R7 locked unchanged");
      rd(P_RD, 8'h05, 8'h5A, "R7 verify allowed");

      // R8 lock level 3
      strobe(P_L2, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, "R8 lock2 busy");
      rd(P_RD, 8'h05, 8'h00, "R8 verify blocked");
      rd(P_SG, 8'h31, 8'h61, "R6 sig when locked");
      expect_at(cyc, K_EXT, 8'd1, "R9 ext level3");
      step();

      // R9 lock level 4
      strobe(P_L3, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, "R9 lock3 busy");
      expect_at(cyc, K_EXT, 8'd0, "R9 ext level4");
      step();

      // R5 short erase does nothing
      erase_pulse(ET - 2);
      expect_at(cyc, K_EXT, 8'd0, "R5 short erase");
      rd(P_RD, 8'h05, 8'h00, "R5 short erase locks kept");

      // R5 full erase
      erase_pulse(ET + 3);
      expect_at(cyc, K_EXT, 8'd1, "R5 erase clears locks");
      rd(P_RD, 8'h05, 8'hFF, "R5 erased");
      rd(P_RD, 8'h09, 8'hFF, "R5 erased other");
      strobe(P_WR, 8'h05, 8'h0F, 1'b1, 1'b1, 1'b1, "R5 rewrite busy");
      rd(P_RD, 8'h05, 8'h0F, "R5 rewrite data");

      repeat (4) step();
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule